// File: doc/BRIEF.md
# Narrow Float to Single-Precision Widener

This block takes one small floating-point code and returns the equal IEEE-754 single-precision word. It handles five narrow layouts. A 3-bit select picks the layout. The narrow code sits right-aligned in an 8-bit input, and any bits above the chosen width are discarded.

The block splits the code into sign, exponent and mantissa and classifies it. A normal value is re-biased to the single-precision exponent, with the mantissa placed at the top of the fraction. A subnormal value is normalised with a leading-zero count. Zeros, infinities and NaNs follow the rules of the chosen layout. Only the widest layout has infinities. One 8-bit layout reserves a single all-ones pattern per sign for NaN. The 6-bit and 4-bit layouts have no special values.

The converted word is registered once. It appears one clock after the qualifying input strobe, together with its own strobe.

Top module: `nfp_upconv`

## Requirements
- R1: With select 0 (8-bit, 1 sign, 5 exponent, 2 mantissa bits, bias 15), normal codes convert exactly: 0x3C gives 0x3F800000, 0xBC gives 0xBF800000 and 0x7B gives 0x47600000.
- R2: With select 0, exponent field 31 with mantissa 0 gives a signed infinity (0x7C gives 0x7F800000, 0xFC gives 0xFF800000). Exponent field 31 with a nonzero mantissa gives NaN.
- R3: With select 1 (8-bit, 1 sign, 4 exponent, 3 mantissa bits, bias 7), only exponent 15 together with mantissa 7 is NaN. Every other exponent-15 code is finite: 0x7E gives 0x43E00000 and 0x7D gives 0x43D00000. Code 0x38 gives 1.0.
- R4: Select 2 (6-bit, 3 exponent, 2 mantissa, bias 3) and select 3 (6-bit, 2 exponent, 3 mantissa, bias 1) never give infinity or NaN. Select 2 maps 0x1F to 0x41E00000. Select 3 maps 0x1F to 0x40F00000.
- R5: Select 4 (4-bit, 2 exponent, 1 mantissa, bias 1) is all finite: 0x2 gives 1.0 and 0x7 gives 0x40C00000.
- R6: A subnormal code is normalised. The leading mantissa one becomes implicit and the exponent drops by its position. Examples: select 0 code 0x01 gives 0x37800000, select 1 gives 0x3B000000, select 2 gives 0x3D800000, select 3 gives 0x3E000000, and select 4 code 0x1 gives 0x3F000000.
- R7: A zero code keeps its sign: positive zero gives 0x00000000 and negative zero gives 0x80000000.
- R8: Every NaN result is exactly 0x7FC00000, whatever the input sign.
- R9: Input bits above the selected code width (bit 7 and up minus the width) do not affect the result.
- R10: Select values 5, 6 and 7 give 0x7FC00000.
- R11: `out_vld` is `in_vld` delayed by exactly one clock. Back-to-back inputs produce back-to-back results in order.
- R12: A synchronous active-high reset clears `out_vld` and `out_word` to 0. While `in_vld` is low, `out_word` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input code is valid this cycle |
| fmt_sel | input | 3 | Layout select, 0 to 4; 5 to 7 are unused |
| code_in | input | 8 | Narrow code, right-aligned |
| out_vld | output | 1 | Result valid |
| out_word | output | 32 | Single-precision result |

## Verification
Fixed examples pin each layout's exponent bias and mantissa placement. An exhaustive sweep of every code of every layout, checked against a loop-normalising reference, separates the subnormal, normal and special paths.

Three further directed cases isolate corner behaviour:
- Negative-zero codes test sign retention.
- Negative NaN codes test canonical NaN output.
- Codes with garbage in the upper bits test width masking.

Single strobes, back-to-back strobes and idle gaps tell a one-cycle latency apart from a missing or doubled register stage and from a result that fails to hold.

// File: rtl/nfp_pkg.sv
package nfp_pkg;

    localparam int CODE_W    = 8;
    localparam int SEL_W     = 3;
    localparam int WORD_W    = 32;
    localparam int EXP32_W   = 8;
    localparam int FRAC32_W  = 23;
    localparam int MAN_AL_W  = 3;
    localparam int EXP_RAW_W = 5;
    localparam int BIAS_W    = 5;
    localparam int EXP32_BIAS = 127;
    localparam int FRAC_PAD_W = FRAC32_W - MAN_AL_W;
    localparam logic [WORD_W-1:0] QNAN_WORD = 32'h7FC0_0000;

    typedef enum logic [SEL_W-1:0] {
        FMT_E5M2 = 3'd0,
        FMT_E4M3 = 3'd1,
        FMT_E3M2 = 3'd2,
        FMT_E2M3 = 3'd3,
        FMT_E2M1 = 3'd4
    } nfp_fmt_e;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } nfp_cls_e;

    typedef struct packed {
        logic [2:0]        ew;
        logic [1:0]        mw;
        logic [BIAS_W-1:0] bias;
        logic              ok;
    } nfp_layout_t;

    typedef struct packed {
        logic                 sign;
        nfp_cls_e             cls;
        logic [EXP_RAW_W-1:0] exp_raw;
        logic [MAN_AL_W-1:0]  man_al;
        logic [BIAS_W-1:0]    bias;
    } nfp_fields_t;

    function automatic nfp_layout_t layout_of(input logic [SEL_W-1:0] sel);
        nfp_layout_t l;
        l = '{ew: 3'd0, mw: 2'd0, bias: 5'd0, ok: 1'b0};
        case (sel)
            FMT_E5M2: l = '{ew: 3'd5, mw: 2'd2, bias: 5'd15, ok: 1'b1};
            FMT_E4M3: l = '{ew: 3'd4, mw: 2'd3, bias: 5'd7,  ok: 1'b1};
            FMT_E3M2: l = '{ew: 3'd3, mw: 2'd2, bias: 5'd3,  ok: 1'b1};
            FMT_E2M3: l = '{ew: 3'd2, mw: 2'd3, bias: 5'd1,  ok: 1'b1};
            FMT_E2M1: l = '{ew: 3'd2, mw: 2'd1, bias: 5'd1,  ok: 1'b1};
            default:  l = '{ew: 3'd0, mw: 2'd0, bias: 5'd0,  ok: 1'b0};
        endcase
        return l;
    endfunction

    // Leading zeros of a left-aligned 3-bit mantissa (input never zero on use)
    function automatic logic [1:0] lead_zeros3(input logic [MAN_AL_W-1:0] m);
        logic [1:0] n;
        casez (m)
            3'b1??:  n = 2'd0;
            3'b01?:  n = 2'd1;
            default: n = 2'd2;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/nfp_decode.sv
module nfp_decode
    import nfp_pkg::*;
(
    input  logic [SEL_W-1:0]  fmt_sel,
    input  logic [CODE_W-1:0] code_in,
    output nfp_fields_t       fields
);
    nfp_layout_t         lay;
    logic [3:0]          sign_pos;
    logic [CODE_W-1:0]   man_mask;
    logic [CODE_W-1:0]   exp_mask;
    logic [CODE_W-1:0]   man_raw;
    logic [CODE_W-1:0]   exp_bits;
    logic [MAN_AL_W-1:0] man_al;
    logic [1:0]          al_shift;
    logic                exp_full;
    logic                man_full;

    always_comb begin
        lay      = layout_of(fmt_sel);
        sign_pos = {1'b0, lay.ew} + {2'b0, lay.mw};
        man_mask = (8'd1 << lay.mw) - 8'd1;
        exp_mask = (8'd1 << lay.ew) - 8'd1;
        man_raw  = code_in & man_mask;
        exp_bits = (code_in >> lay.mw) & exp_mask;
        al_shift = 2'd3 - lay.mw;
        man_al   = man_raw[MAN_AL_W-1:0] << al_shift;
        exp_full = (exp_bits == exp_mask);
        man_full = (man_raw == man_mask);

        fields.sign    = code_in[sign_pos[2:0]];
        fields.exp_raw = exp_bits[EXP_RAW_W-1:0];
        fields.man_al  = man_al;
        fields.bias    = lay.bias;

        if (!lay.ok)
            fields.cls = CLS_NAN;
        else if (fmt_sel == FMT_E5M2 && exp_full)
            fields.cls = (man_raw == '0) ? CLS_INF : CLS_NAN;
        else if (fmt_sel == FMT_E4M3 && exp_full && man_full)
            fields.cls = CLS_NAN;
        else if (exp_bits == '0)
            fields.cls = (man_raw == '0) ? CLS_ZERO : CLS_SUB;
        else
            fields.cls = CLS_NORM;
    end

endmodule

// File: rtl/nfp_pack.sv
module nfp_pack
    import nfp_pkg::*;
(
    input  nfp_fields_t       fields,
    output logic [WORD_W-1:0] word
);
    logic [1:0]           lz;
    logic [2:0]           sub_shift;
    logic [MAN_AL_W-1:0]  sub_frac;
    logic [EXP32_W-1:0]   norm_exp;
    logic [EXP32_W-1:0]   sub_exp;

    always_comb begin
        lz        = lead_zeros3(fields.man_al);
        sub_shift = {1'b0, lz} + 3'd1;
        sub_frac  = fields.man_al << sub_shift;
        norm_exp  = EXP32_W'(EXP32_BIAS) + {3'b0, fields.exp_raw} - {3'b0, fields.bias};
        sub_exp   = EXP32_W'(EXP32_BIAS) - {3'b0, fields.bias} - {6'b0, lz};

        case (fields.cls)
            CLS_ZERO: word = {fields.sign, 31'b0};
            CLS_INF:  word = {fields.sign, 8'hFF, 23'b0};
            CLS_NORM: word = {fields.sign, norm_exp, fields.man_al, {FRAC_PAD_W{1'b0}}};
            CLS_SUB:  word = {fields.sign, sub_exp, sub_frac, {FRAC_PAD_W{1'b0}}};
            default:  word = QNAN_WORD;
        endcase
    end

endmodule

// File: rtl/nfp_upconv.sv
module nfp_upconv
    import nfp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_vld,
    input  logic [SEL_W-1:0]   fmt_sel,
    input  logic [CODE_W-1:0]  code_in,
    output logic               out_vld,
    output logic [WORD_W-1:0]  out_word
);
    nfp_fields_t       fields;
    logic [WORD_W-1:0] word_nxt;

    nfp_decode u_decode (
        .fmt_sel (fmt_sel),
        .code_in (code_in),
        .fields  (fields)
    );

    nfp_pack u_pack (
        .fields (fields),
        .word   (word_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_word <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld)
                out_word <= word_nxt;
        end
    end

    // R11
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(out_word));

    // R8
    nan_canon_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_word[30:23] == 8'hFF && out_word[22:0] != 23'd0)
        |-> out_word == QNAN_WORD);

    // R4
    finite_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (fmt_sel == 3'd2 || fmt_sel == 3'd3 || fmt_sel == 3'd4))
        |=> out_word[30:23] != 8'hFF);

    // R7
    zero_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && fmt_sel == 3'd0 && code_in[6:0] == 7'd0)
        |=> out_word == {$past(code_in[7]), 31'b0});

endmodule

// File: tb/tb_nfp_upconv.sv
`timescale 1ns/1ps
module tb_nfp_upconv;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [2:0]  fmt_sel;
    logic [7:0]  code_in;
    logic        out_vld;
    logic [31:0] out_word;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    nfp_upconv dut (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .fmt_sel  (fmt_sel),
        .code_in  (code_in),
        .out_vld  (out_vld),
        .out_word (out_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Independent reference: loop normalisation, no leading-zero table
    function automatic logic [31:0] model(input int f, input logic [7:0] c);
        int ew, mw, bias, w, v, s, e, m, emax, sig, ex;
        case (f)
            0: begin ew = 5; mw = 2; bias = 15; end
            1: begin ew = 4; mw = 3; bias = 7;  end
            2: begin ew = 3; mw = 2; bias = 3;  end
            3: begin ew = 2; mw = 3; bias = 1;  end
            4: begin ew = 2; mw = 1; bias = 1;  end
            default: return 32'h7FC00000;
        endcase
        w    = 1 + ew + mw;
        v    = int'(c) & ((1 << w) - 1);
        s    = (v >> (ew + mw)) & 1;
        e    = (v >> mw) & ((1 << ew) - 1);
        m    = v & ((1 << mw) - 1);
        emax = (1 << ew) - 1;
        if (f == 0 && e == emax)
            return (m == 0) ? {s[0], 8'hFF, 23'd0} : 32'h7FC00000;
        if (f == 1 && e == emax && m == 7)
            return 32'h7FC00000;
        if (e == 0 && m == 0)
            return {s[0], 31'd0};
        sig = (e == 0) ? m : ((1 << mw) | m);
        ex  = ((e == 0) ? 1 : e) - bias - mw;
        while (sig < (1 << 23)) begin
            sig = sig << 1;
            ex  = ex - 1;
        end
        return {s[0], 8'(ex + 150), sig[22:0]};
    endfunction

    task automatic convert(input logic [2:0] f, input logic [7:0] c, output logic [31:0] res);
        @(negedge clk);
        in_vld  = 1'b1;
        fmt_sel = f;
        code_in = c;
        @(negedge clk);
        in_vld  = 1'b0;
        res     = out_word;
    endtask

    task automatic expect_code(input string req, input logic [2:0] f, input logic [7:0] c,
                               input logic [31:0] exp);
        logic [31:0] r;
        convert(f, c, r);
        check(req, r, exp);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_vld = 1'b0; fmt_sel = 3'd0; code_in = 8'd0;
        repeat (3) @(negedge clk);
        check("R12 reset vld", {31'd0, out_vld}, 32'd0);
        check("R12 reset word", out_word, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_examples;
        expect_code("R1", 3'd0, 8'h3C, 32'h3F800000);
        expect_code("R1", 3'd0, 8'hBC, 32'hBF800000);
        expect_code("R1", 3'd0, 8'h7B, 32'h47600000);
        expect_code("R2", 3'd0, 8'h7C, 32'h7F800000);
        expect_code("R2", 3'd0, 8'hFC, 32'hFF800000);
        expect_code("R2", 3'd0, 8'h7D, 32'h7FC00000);
        expect_code("R3", 3'd1, 8'h7E, 32'h43E00000);
        expect_code("R3", 3'd1, 8'h7D, 32'h43D00000);
        expect_code("R3", 3'd1, 8'h38, 32'h3F800000);
        expect_code("R3", 3'd1, 8'h7F, 32'h7FC00000);
        expect_code("R4", 3'd2, 8'h1F, 32'h41E00000);
        expect_code("R4", 3'd2, 8'h0C, 32'h3F800000);
        expect_code("R4", 3'd2, 8'h2C, 32'hBF800000);
        expect_code("R4", 3'd3, 8'h1F, 32'h40F00000);
        expect_code("R4", 3'd3, 8'h08, 32'h3F800000);
        expect_code("R5", 3'd4, 8'h02, 32'h3F800000);
        expect_code("R5", 3'd4, 8'h07, 32'h40C00000);
    endtask

    task automatic t_subnormal;
        expect_code("R6", 3'd0, 8'h01, 32'h37800000);
        expect_code("R6", 3'd1, 8'h01, 32'h3B000000);
        expect_code("R6", 3'd2, 8'h01, 32'h3D800000);
        expect_code("R6", 3'd3, 8'h01, 32'h3E000000);
        expect_code("R6", 3'd4, 8'h01, 32'h3F000000);
    endtask

    task automatic t_zero_sign;
        expect_code("R7", 3'd0, 8'h00, 32'h00000000);
        expect_code("R7", 3'd0, 8'h80, 32'h80000000);
        expect_code("R7", 3'd1, 8'h80, 32'h80000000);
        expect_code("R7", 3'd2, 8'h20, 32'h80000000);
        expect_code("R7", 3'd4, 8'h08, 32'h80000000);
    endtask

    task automatic t_nan_sign;
        expect_code("R8", 3'd0, 8'hFF, 32'h7FC00000);
        expect_code("R8", 3'd1, 8'hFF, 32'h7FC00000);
    endtask

    task automatic t_upper_ignored;
        expect_code("R9", 3'd2, 8'hCC, 32'h3F800000);
        expect_code("R9", 3'd3, 8'h48, 32'h3F800000);
        expect_code("R9", 3'd4, 8'hF2, 32'h3F800000);
        expect_code("R9", 3'd4, 8'hA7, 32'h40C00000);
    endtask

    task automatic t_unused_sel;
        expect_code("R10", 3'd5, 8'h3C, 32'h7FC00000);
        expect_code("R10", 3'd6, 8'h00, 32'h7FC00000);
        expect_code("R10", 3'd7, 8'h80, 32'h7FC00000);
    endtask

    task automatic t_sweep;
        int n;
        for (int f = 0; f < 5; f++) begin
            n = (f < 2) ? 256 : (f < 4) ? 64 : 16;
            for (int c = 0; c < n; c++) begin
                logic [31:0] r;
                convert(3'(f), 8'(c), r);
                check($sformatf("R1-R6 sweep f%0d c%0h", f, c), r, model(f, 8'(c)));
            end
        end
    endtask

    task automatic t_timing;
        logic [31:0] held;
        @(negedge clk);
        in_vld = 1'b1; fmt_sel = 3'd0; code_in = 8'h3C;
        @(negedge clk);
        check("R11 vld after 1", {31'd0, out_vld}, 32'd1);
        check("R11 stream 1", out_word, 32'h3F800000);
        code_in = 8'h01;
        @(negedge clk);
        check("R11 stream 2", out_word, 32'h37800000);
        fmt_sel = 3'd4; code_in = 8'h07;
        @(negedge clk);
        in_vld = 1'b0;
        check("R11 stream 3", out_word, 32'h40C00000);
        held = out_word;
        code_in = 8'h01;
        @(negedge clk);
        check("R11 vld drops", {31'd0, out_vld}, 32'd0);
        check("R12 hold", out_word, held);
        @(negedge clk);
        check("R12 hold 2", out_word, held);
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_examples();
        t_subnormal();
        t_zero_sign();
        t_nan_sign();
        t_upper_ignored();
        t_unused_sel();
        t_timing();
        t_sweep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule